// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Engine

This block is a free-running read master for a raster display path. Once software turns it on, it walks a frame buffer in memory one word at a time and pushes the returned words into a pixel FIFO. It keeps several reads in flight to sustain bandwidth. It throttles itself on the FIFO fill level that the FIFO reports, and it restarts at the frame start after the last word of each frame.

With the double-buffer build option the engine switches to the other of two frame base addresses at every frame boundary. Software may rewrite either base address at any time. A new value waits in a shadow register and only takes effect when the engine next loads that buffer. The frame size in words is derived at build time from the horizontal and vertical pixel counts and the pixel depth.

Top module: `frame_fetch_dma`

## Requirements
- R1: While reset is asserted, `mem_read`, `fifo_wr` and `cur_buf` are 0.
- R2: A frame holds `H_PIX*V_PIX/2` words for 16-bit pixels and `H_PIX*V_PIX` words for 24-bit pixels, with one 24-bit pixel per 32-bit word. Each accepted read (a cycle with `mem_read`=1 and `mem_waitreq`=0) uses the byte address `active_base + 4*k`, where k is the word index. k counts up by one per accepted read and returns to 0 after the last word of the frame.
- R3: A read is issued only while the FIFO free space (`FIFO_DEPTH - fifo_level`) exceeds the number of reads in flight. No more than `MAX_OUT` reads are ever outstanding, and `fifo_wr` is never asserted while `fifo_level` equals `FIFO_DEPTH`. If the FIFO is never drained, the FIFO fills completely and the read strobe stays low.
- R4: Reads are pipelined, so more than one read can be outstanding. Every `mem_rvalid` cycle asserts `fifo_wr` in the same cycle with `fifo_wdata` equal to `mem_rdata`. Words therefore reach the FIFO in request order.
- R5: While `mem_read` is high and `mem_waitreq` is high, `mem_read` stays high and `mem_addr` stays unchanged in the next cycle.
- R6: With `DOUBLE_BUF`=1, `cur_buf` toggles one cycle after the last word of a frame is accepted, and the next frame is fetched from the other base. With `DOUBLE_BUF`=0, `cur_buf` stays 0. `cur_buf` changes at no other time.
- R7: The configuration port uses a register select. Select 0 sets enable from `cfg_wdata[0]`. Select 1 writes the shadow base of buffer 0, and select 2 writes the shadow base of buffer 1. A shadow base is copied into the active base only at a frame wrap, for the buffer about to be fetched. It is also copied while the engine is disabled at word index 0 with no read pending.
- R8: After enable is cleared, no new read is raised, but reads already in flight still return and are written to the FIFO. Re-enabling resumes at the next word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 base 0, 2 base 1 |
| cfg_wdata | input | ADDR_W | Configuration write data |
| mem_addr | output | ADDR_W | Read byte address |
| mem_read | output | 1 | Read request strobe |
| mem_waitreq | input | 1 | Memory stall; request not taken this cycle |
| mem_rdata | input | DATA_W | Returned read data |
| mem_rvalid | input | 1 | Returned data valid |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |
| fifo_level | input | LVL_W | Current FIFO fill level |
| cur_buf | output | 1 | Buffer currently being fetched |

## Verification
A wrong word index or active base shows up at the next accepted read as a wrong address. A wrong buffer select shows up at the first read of the next frame, and the bench compares every accepted address against its own model. A drifting in-flight count first appears as a read that is issued with no FIFO room left. With the FIFO never drained, this becomes an overflowing write within a few latency periods. A failure to hold a stalled request is visible one cycle after the stall.

// File: rtl/frame_fetch_pkg.sv
package frame_fetch_pkg;
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_BASE0 = 2'd1;
  localparam logic [1:0] SEL_BASE1 = 2'd2;

  // Words per frame: 16-bit pixels pack two per word, 24-bit pixels use one word.
  function automatic int frame_words(int h, int v, int bits);
    return (bits == 16) ? (h * v) / 2 : h * v;
  endfunction
endpackage

// File: rtl/fetch_cfg_regs.sv
module fetch_cfg_regs #(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output logic                  en_q,
  output logic [1:0][ADDR_W-1:0] base_sh
);
  import frame_fetch_pkg::*;

  logic en_ce;
  assign en_ce = cfg_we && (cfg_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= cfg_wdata[0];
  end

  for (genvar b = 0; b < 2; b++) begin : g_base
    logic ce;
    assign ce = cfg_we && (cfg_sel == ((b == 0) ? SEL_BASE0 : SEL_BASE1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  base_sh[b] <= '0;
      else if (ce) base_sh[b] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/fetch_req_ctrl.sv
module fetch_req_ctrl #(
  parameter int FIFO_DEPTH = 256,
  parameter int MAX_OUT    = 8,
  parameter int LVL_W      = 9,
  parameter int OUT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             mem_waitreq,
  input  logic             mem_rvalid,
  output logic             mem_read,
  output logic             accept
);
  localparam int CW = LVL_W + 1;

  logic [OUT_W-1:0] out_q, out_n;
  logic [CW-1:0]    free_sp, in_flight;
  logic             issue_ok, read_n;

  assign accept = mem_read && !mem_waitreq;

  always_comb begin
    out_n     = out_q + OUT_W'(accept) - OUT_W'(mem_rvalid);
    free_sp   = CW'(FIFO_DEPTH) - {1'b0, fifo_level};
    in_flight = CW'(out_q) + CW'(accept);
    issue_ok  = en_q && (free_sp > in_flight) && (in_flight < CW'(MAX_OUT));
    read_n    = (mem_read && mem_waitreq) ? 1'b1 : issue_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      mem_read <= 1'b0;
    end else begin
      out_q    <= out_n;
      mem_read <= read_n;
    end
  end
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 153600,
  parameter int IDX_W       = 18,
  parameter bit DOUBLE_BUF  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_q,
  input  logic                   mem_read,
  input  logic                   accept,
  input  logic [1:0][ADDR_W-1:0] base_sh,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   cur_buf
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);

  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic              buf_n, last, idle, wrap;

  always_comb begin
    last   = (idx_q == IDX_W'(FRAME_WORDS - 1));
    wrap   = accept && last;
    idle   = !en_q && (idx_q == '0) && !mem_read;
    idx_n  = idx_q;
    buf_n  = cur_buf;
    base_n = base_q;
    if (accept) idx_n = last ? '0 : idx_q + 1'b1;
    if (wrap) begin
      if (DOUBLE_BUF) buf_n = ~cur_buf;
      base_n = base_sh[buf_n];
    end else if (idle) begin
      base_n = base_sh[cur_buf];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      base_q  <= '0;
      cur_buf <= 1'b0;
    end else begin
      idx_q   <= idx_n;
      base_q  <= base_n;
      cur_buf <= buf_n;
    end
  end

  assign mem_addr = base_q + (ADDR_W'(idx_q) << BYTE_SH);
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int H_PIX      = 640,
  parameter int V_PIX      = 480,
  parameter int PIX_BITS   = 16,
  parameter int FIFO_DEPTH = 256,
  parameter int MAX_OUT    = 8,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_read,
  input  logic              mem_waitreq,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              cur_buf
);
  localparam int FRAME_WORDS = frame_fetch_pkg::frame_words(H_PIX, V_PIX, PIX_BITS);
  localparam int IDX_W       = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam int OUT_W       = $clog2(MAX_OUT + 1);

  logic                   en_q, accept;
  logic [1:0][ADDR_W-1:0] base_sh;

  fetch_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en_q(en_q), .base_sh(base_sh)
  );

  fetch_req_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_OUT(MAX_OUT), .LVL_W(LVL_W), .OUT_W(OUT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .fifo_level(fifo_level),
    .mem_waitreq(mem_waitreq), .mem_rvalid(mem_rvalid),
    .mem_read(mem_read), .accept(accept)
  );

  fetch_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS),
                   .IDX_W(IDX_W), .DOUBLE_BUF(DOUBLE_BUF)) u_addr (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .mem_read(mem_read), .accept(accept),
    .base_sh(base_sh), .mem_addr(mem_addr), .cur_buf(cur_buf)
  );

  // Returned words go straight into the FIFO, so they keep request order.
  assign fifo_wr    = mem_rvalid;
  assign fifo_wdata = mem_rdata;
endmodule

// File: rtl/frame_fetch_dma_chk.sv
module frame_fetch_dma_chk #(
  parameter int ADDR_W     = 32,
  parameter int LVL_W      = 9,
  parameter int FIFO_DEPTH = 256,
  parameter int MAX_OUT    = 8,
  parameter bit DOUBLE_BUF = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_read,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_waitreq,
  input logic              mem_rvalid,
  input logic              fifo_wr,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              cur_buf
);
  logic [15:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend + 16'(mem_read && !mem_waitreq) - 16'(mem_rvalid);
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!mem_read && !fifo_wr && !cur_buf);
  end

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read && mem_waitreq |=> mem_read && $stable(mem_addr));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (int'(fifo_level) < FIFO_DEPTH));

  assert_room_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fifo_level) + int'(pend)) <= FIFO_DEPTH);

  assert_max_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend) <= MAX_OUT);

  assert_flip_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_buf) |-> $past(mem_read && !mem_waitreq));

  if (!DOUBLE_BUF) begin : g_single
    assert_single_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cur_buf == 1'b0);
  end
endmodule

bind frame_fetch_dma frame_fetch_dma_chk #(
  .ADDR_W(ADDR_W), .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH),
  .MAX_OUT(MAX_OUT), .DOUBLE_BUF(DOUBLE_BUF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_read(mem_read), .mem_addr(mem_addr),
  .mem_waitreq(mem_waitreq), .mem_rvalid(mem_rvalid), .fifo_wr(fifo_wr),
  .fifo_level(fifo_level), .cur_buf(cur_buf)
);

// File: tb/frame_fetch_dma_tb_top.sv
module frame_fetch_dma_tb_top;
  localparam int AW = 32, DW = 32, HP = 8, VP = 4, PB = 16;
  localparam int DEPTH = 8, MAXO = 4, LAT = 3;
  localparam int FW = HP * VP / 2;             // 16 words per frame
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_sel;
  logic [AW-1:0] cfg_wdata, mem_addr;
  logic mem_read, mem_waitreq, mem_rvalid, fifo_wr, cur_buf;
  logic [DW-1:0] mem_rdata, fifo_wdata;
  logic [LW-1:0] fifo_level;

  always #5 clk = ~clk;

  frame_fetch_dma #(.ADDR_W(AW), .DATA_W(DW), .H_PIX(HP), .V_PIX(VP), .PIX_BITS(PB),
                    .FIFO_DEPTH(DEPTH), .MAX_OUT(MAXO), .DOUBLE_BUF(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_addr(mem_addr), .mem_read(mem_read), .mem_waitreq(mem_waitreq),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .fifo_level(fifo_level), .cur_buf(cur_buf)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] dat(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // Bench models
  logic [31:0] sh [2];
  logic [31:0] q_addr [32];
  int          q_due  [32];
  int head = 0, tail = 0, cyc = 0, level = 0, exp_idx = 0, max_out = 0;
  int n_acc = 0, n_ret = 0, wait_mode = 0, pop_mode = 0;
  bit en_m = 0, en_prev = 0, exp_buf = 0, held = 0, pop = 0, rv = 0;
  logic [31:0] exp_base = '0, held_addr = '0;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    sh[0] = '0; sh[1] = '0;
    mem_waitreq = 0; mem_rvalid = 0; mem_rdata = '0; fifo_level = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (held) chk(mem_read && mem_addr == held_addr, "R5 stalled request held", mem_addr, held_addr);
        chk(cur_buf == exp_buf, "R6 current buffer", cur_buf, exp_buf);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_waitreq = (wait_mode == 1) ? lfsr[0] : (wait_mode == 2) ? (cyc % 4 != 0) : 1'b0;
      rv = (tail != head) && (q_due[head % 32] <= cyc);
      mem_rvalid = rv;
      mem_rdata  = rv ? dat(q_addr[head % 32]) : '0;
      pop = (level > 0) && (pop_mode == 1 || (pop_mode == 2 && cyc % 3 == 0));
      fifo_level = LW'(level);
      #1;
      if (rst_n) begin
        if (mem_read && !held) chk(en_prev, "R8 read raised only while enabled", 0, 1);
        if (rv) begin
          chk(fifo_wr && fifo_wdata == dat(q_addr[head % 32]), "R4 returned word in order",
              fifo_wdata, dat(q_addr[head % 32]));
          chk(level < DEPTH, "R3 no write into full FIFO", level, DEPTH - 1);
          head++; n_ret++;
        end else if (fifo_wr) chk(0, "R4 spurious FIFO write", 1, 0);
        if (!en_m && exp_idx == 0 && !mem_read) exp_base = sh[exp_buf];
        if (mem_read && !mem_waitreq) begin
          chk(mem_addr == exp_base + 32'(exp_idx * 4), (exp_idx == 0) ? "R7 frame start base" : "R2 word address",
              mem_addr, exp_base + 32'(exp_idx * 4));
          q_addr[tail % 32] = mem_addr; q_due[tail % 32] = cyc + LAT; tail++; n_acc++;
          if (exp_idx == FW - 1) begin
            exp_idx = 0; exp_buf = ~exp_buf; exp_base = sh[exp_buf];
          end else exp_idx++;
        end
        if (tail - head > max_out) max_out = tail - head;
        chk(tail - head <= MAXO, "R3 outstanding limit", tail - head, MAXO);
        held = mem_read && mem_waitreq;
        held_addr = mem_addr;
        level = level + int'(rv) - int'(pop);
        en_prev = en_m;
        if (cfg_we) begin
          case (cfg_sel)
            2'd0: en_m = cfg_wdata[0];
            2'd1: sh[0] = cfg_wdata;
            2'd2: sh[1] = cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(!mem_read, "R1 read idle in reset", mem_read, 0);
    chk(!fifo_wr, "R1 no FIFO write in reset", fifo_wr, 0);
    chk(!cur_buf, "R1 buffer 0 in reset", cur_buf, 0);
    @(negedge clk); rst_n = 1;
    // R7 register map: select 1/2 bases, select 0 enable
    wr(2'd1, 32'h0000_1000);
    wr(2'd2, 32'h0000_8000);
    pop_mode = 1;
    wr(2'd0, 32'h1);
    run(60);
    wait_mode = 1; pop_mode = 2;
    run(30);
    wr(2'd1, 32'h0000_2000);            // R7 pending base change mid-frame
    run(100);
    pop_mode = 0; wait_mode = 0;
    run(40);
    chk(level == DEPTH, "R3 FIFO filled without overflow", level, DEPTH);
    chk(!mem_read, "R3 reads stop when FIFO full", mem_read, 0);
    pop_mode = 1;
    run(20);
    wr(2'd0, 32'h0);                    // R8 disable
    run(20);
    chk(!mem_read, "R8 no reads after disable", mem_read, 0);
    chk(n_acc == n_ret, "R8 in-flight reads delivered", n_ret, n_acc);
    wr(2'd2, 32'h0000_C000);
    wr(2'd0, 32'h1);
    wait_mode = 2;
    run(120);
    chk(max_out >= 2, "R4 pipelined reads", max_out, 2);
    chk(n_acc > 3 * FW, "R2 several frames fetched", n_acc, 3 * FW);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    summary();
  end
endmodule